// File: doc/BRIEF.md
# Connection Memory Initialization Engine

After power-up a switching connection memory holds random words. This engine clears it. Software arms a diagnostic pass through a small register port. The engine then walks every location of the 1024-entry, 16-bit memory and writes one word per clock. Each word has its 6-bit control field cleared, and its 10-bit lower field is loaded with the location's own index.

When the last location has been written, the engine sets a done status bit. That bit stays set until software leaves diagnostic mode. Three registers are involved: a mode register, a pointer register and a data register. A pass starts only when all of the following hold:
- the mode register holds 0x00,
- the pointer holds 0x30,
- 0x0C is written to the data register.

Writing 0x00 to the data register while the pointer holds 0x30 leaves diagnostic mode.

Top module: `cmem_init_engine`

## Requirements
- R1: After reset, `busy`, `done` and `mem_we` are 0. The mode register resets to 0xFF and the pointer register resets to 0x00.
- R2: The register selects are: `reg_addr` 0 for mode, 1 for pointer, 2 for data. A pass starts when 0x0C is written to the data register while mode holds 0x00, the pointer holds 0x30 and no pass is running. `busy` is 1 from the cycle after that write.
- R3: While `busy` is 1, `mem_we` is 1 and `mem_addr` steps by one each cycle, from 0 up to 1023. The pass therefore writes exactly 1024 cycles.
- R4: Every written word has bits [15:10] equal to zero and bits [9:0] equal to `mem_addr`.
- R5: In the cycle after the write to address 1023, `busy` is 0 and `done` is 1. `busy` and `done` are never 1 together.
- R6: A start write made while a pass is running is ignored. The address sequence continues without restarting.
- R7: With mode 0x00 and the pointer at 0x30, a data write of any value other than 0x0C or 0x00 starts nothing and leaves `done` unchanged.
- R8: A data write of 0x0C does not start a pass when mode is not 0x00 or when the pointer is not 0x30.
- R9: A data write of 0x00 while the pointer holds 0x30 clears `done` in the next cycle, with any mode value. If a pass is running, it still completes and then sets `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 mode, 1 pointer, 2 data |
| reg_wdata | input | 8 | Register write data |
| mem_we | output | 1 | Connection memory write enable |
| mem_addr | output | 10 | Connection memory write address |
| mem_wdata | output | 16 | Connection memory write word |
| busy | output | 1 | Pass in progress |
| done | output | 1 | Completion status bit |

## Verification
The hardest conditions to reach are a start request arriving in the middle of a running pass, and an exit request arriving while the memory is still being written. The stimulus reaches both by timing register writes a fixed number of cycles after a valid start, hundreds of locations into the walk. The stimulus also exercises near-miss arming states: a wrong mode, a wrong pointer and a wrong data code. A behavioural model run in parallel flags any unintended start on the following cycle.

// File: rtl/cmem_init_engine.sv
module cmem_init_engine #(
  parameter int IDX_W    = 10,
  parameter int CTRL_W   = 6,
  parameter int RA_W     = 2,
  parameter int RD_W     = 8,
  parameter int MODE_SEL = 0,
  parameter int PTR_SEL  = 1,
  parameter int DATA_SEL = 2,
  parameter logic [RD_W-1:0] DIAG_PTR   = 8'h30,
  parameter logic [RD_W-1:0] START_CODE = 8'h0C,
  parameter logic [RD_W-1:0] EXIT_CODE  = 8'h00,
  parameter logic [RD_W-1:0] MODE_ARM   = 8'h00,
  parameter logic [RD_W-1:0] MODE_RST   = 8'hFF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [RA_W-1:0]         reg_addr,
  input  logic [RD_W-1:0]         reg_wdata,
  output logic                    mem_we,
  output logic [IDX_W-1:0]        mem_addr,
  output logic [CTRL_W+IDX_W-1:0] mem_wdata,
  output logic                    busy,
  output logic                    done
);
  localparam int WORD_W = CTRL_W + IDX_W;
  localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};

  logic [RD_W-1:0]  mode_q, ptr_q;
  logic [IDX_W-1:0] idx_q;
  logic             busy_q, done_q;

  wire wr_mode  = reg_wr && (reg_addr == RA_W'(MODE_SEL));
  wire wr_ptr   = reg_wr && (reg_addr == RA_W'(PTR_SEL));
  wire wr_data  = reg_wr && (reg_addr == RA_W'(DATA_SEL));
  wire at_diag  = (ptr_q == DIAG_PTR);
  wire armed    = at_diag && (mode_q == MODE_ARM);
  wire start    = wr_data && armed && (reg_wdata == START_CODE) && !busy_q;
  wire leave    = wr_data && at_diag && (reg_wdata == EXIT_CODE);
  wire last     = (idx_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
      ptr_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= reg_wdata;
      if (wr_ptr)  ptr_q  <= reg_wdata;
      if (start) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        done_q <= 1'b0;
      end else if (busy_q) begin
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
      if (leave) done_q <= 1'b0;
    end
  end

  assign mem_we    = busy_q;
  assign mem_addr  = idx_q;
  assign mem_wdata = {{CTRL_W{1'b0}}, idx_q};
  assign busy      = busy_q;
  assign done      = done_q;
endmodule

// File: rtl/cmem_init_engine_chk.sv
module cmem_init_engine_chk #(
  parameter int IDX_W  = 10,
  parameter int CTRL_W = 6,
  parameter int RA_W   = 2,
  parameter int RD_W   = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    reg_wr,
  input logic [RA_W-1:0]         reg_addr,
  input logic [RD_W-1:0]         reg_wdata,
  input logic                    mem_we,
  input logic [IDX_W-1:0]        mem_addr,
  input logic [CTRL_W+IDX_W-1:0] mem_wdata,
  input logic                    busy,
  input logic                    done
);
  localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mem_addr == '0) && $past(reg_wr) && ($past(reg_wdata) == 8'h0C));

  p_ascend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (mem_addr == $past(mem_addr) + 1'b1));

  p_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata[CTRL_W+IDX_W-1:IDX_W] == '0) && (mem_wdata[IDX_W-1:0] == mem_addr));

  p_finish_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_addr == LAST && !reg_wr) |=> (done && !busy));

  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_addr != LAST) |=> (busy && mem_addr != '0));
endmodule

bind cmem_init_engine cmem_init_engine_chk #(
  .IDX_W(IDX_W), .CTRL_W(CTRL_W), .RA_W(RA_W), .RD_W(RD_W)
) u_chk (.*);

// File: tb/cmem_init_engine_test.sv
`timescale 1ns/1ps
module cmem_init_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic mem_we, busy, done;
  logic [9:0] mem_addr;
  logic [15:0] mem_wdata;

  int checks = 0;
  int fails = 0;

  int m_mode = 255, m_ptr = 0, m_cnt = 0;
  bit m_busy = 0, m_done = 0;

  always #5 clk = ~clk;

  cmem_init_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit was_busy;
    was_busy = m_busy;
    if (!rst_n) begin
      m_mode = 255; m_ptr = 0; m_cnt = 0; m_busy = 0; m_done = 0;
    end else begin
      if (was_busy) begin
        if (m_cnt == 1023) begin m_busy = 0; m_done = 1; end
        else m_cnt++;
      end
      if (reg_wr) begin
        if (reg_addr == 0) m_mode = reg_wdata;
        else if (reg_addr == 1) m_ptr = reg_wdata;
        else if (reg_addr == 2) begin
          if (m_ptr == 8'h30 && m_mode == 0 && reg_wdata == 8'h0C && !was_busy) begin
            m_busy = 1; m_cnt = 0; m_done = 0;
          end
          if (m_ptr == 8'h30 && reg_wdata == 8'h00) m_done = 0;
        end
      end
    end
    #2;
    chk(busy == m_busy, "R6 busy", busy, m_busy);
    chk(mem_we == m_busy, "R3 mem_we", mem_we, m_busy);
    chk(done == m_done, "R5 done", done, m_done);
    if (m_busy) begin
      chk(mem_addr == m_cnt, "R3 mem_addr", mem_addr, m_cnt);
      chk(mem_wdata == m_cnt, "R4 mem_wdata", mem_wdata, m_cnt);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a[1:0]; reg_wdata = d[7:0];
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    chk(busy == 0 && done == 0 && mem_we == 0, "R1 reset", {busy, done, mem_we}, 0);
    rst_n = 1'b1;
    idle(2);
    chk(busy == 0, "R1 mode reset not armed", busy, 0);

    wr(1, 8'h30); wr(2, 8'h0C); idle(3);
    chk(busy == 0, "R8 default mode no start", busy, 0);
    wr(0, 8'h05); wr(2, 8'h0C); idle(3);
    chk(busy == 0, "R8 wrong mode no start", busy, 0);
    wr(0, 8'h00); wr(1, 8'h31); wr(2, 8'h0C); idle(3);
    chk(busy == 0, "R8 wrong pointer no start", busy, 0);
    wr(1, 8'h30); wr(2, 8'h0D); idle(3);
    chk(busy == 0, "R7 wrong code no start", busy, 0);

    wr(2, 8'h0C);
    chk(busy == 1 && mem_addr == 0, "R2 start", mem_addr, 0);
    idle(500);
    wr(2, 8'h0C);
    chk(busy == 1 && mem_addr > 500, "R6 restart ignored", mem_addr, 502);
    idle(600);
    chk(done == 1 && busy == 0, "R5 done after pass", done, 1);
    wr(2, 8'h33); idle(2);
    chk(done == 1, "R7 other code keeps done", done, 1);
    wr(2, 8'h00); idle(1);
    chk(done == 0, "R9 exit clears done", done, 0);

    wr(2, 8'h0C); idle(300);
    wr(2, 8'h00); idle(2);
    chk(busy == 1, "R9 exit does not stop pass", busy, 1);
    idle(800);
    chk(done == 1, "R9 pass completes after exit", done, 1);
    wr(0, 8'h07); wr(2, 8'h00); idle(1);
    chk(done == 0, "R9 exit any mode", done, 0);

    idle(5);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule